// File: doc/BRIEF.md
# Dual-Output Phase-Error Loop Controller

This block is the digital heart of a phase-locked loop that has no time-to-digital converter. It runs on the fast oscillator clock. On every cycle it samples the UP and DN pulses of a phase-frequency detector and keeps a signed running count of how many more cycles UP was high than DN. A reference-rate strobe closes each measurement window. The count of that window becomes the phase-error sample, and a new window starts at zero.

Each sample feeds two filters at once. The first is a proportional-plus-integral filter. Its output is an unsigned tuning word for the digitally controlled oscillator, made of a 4-bit integer part and a 7-bit fraction. The second filter is purely proportional and has no memory. Its output is a 6-bit code that selects one of 64 interpolated clock phases. Every gain is a power of two and is applied as an arithmetic shift. Each output is truncated toward minus infinity before it leaves the block. Both words are registered and change only in the clock cycle after a strobe.

Top module: `adpll_loop_ctrl`

## Requirements
- R1: A cycle where UP is high and DN is low adds one to the window count. A cycle where DN is high and UP is low subtracts one. A cycle where both are high, or both are low, leaves the count unchanged.
- R2: The strobe cycle's pulse is included in the sample. The next window then starts from zero, so no count carries over from one window to the next.
- R3: Both output words hold their values in every cycle except the one that directly follows a strobe.
- R4: After a strobe with sample e, the integrator I gains e·2^-ISH tuning codes. The tuning word becomes mid-scale (1024) + floor(I + e·2^-PSH) in units of 2^-7 code.
- R5: All truncation is floor, toward minus infinity. For example, a fractional sum of -8.125 LSB gives -9 LSB.
- R6: The tuning word is clamped to the range 0..2047. The integrator is clamped to the range that range can express and never wraps. A sample of the opposite sign therefore moves the word off the rail at once.
- R7: The phase-select word is floor(e·2^PSS) for the last sample alone. A zero sample gives code 0.
- R8: The phase-select word is the low 6 bits of that floored product, which equals the product modulo 64. A negative product therefore maps to 64 minus its magnitude.
- R9: A synchronous active-high reset clears the count and the integrator. It sets the tuning word to 1024 and the phase-select word to 0.
- R10: The window count saturates at the limits of its signed width and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| up_i | input | 1 | Detector UP pulse, sampled each cycle |
| dn_i | input | 1 | Detector DN pulse, sampled each cycle |
| ref_tick_i | input | 1 | One-cycle strobe that closes a measurement window |
| tune_o | output | INT_W+FRAC_W | Oscillator tuning word (integer.fraction, unsigned) |
| psel_o | output | PSEL_W | Interpolated phase index |

## Verification
Some properties are checked on every cycle. Both outputs hold between strobes. Coincident pulses leave the count unchanged. A count sitting at its upper limit stays there. The integrator never decreases on a non-negative sample, so it cannot wrap. A zero sample gives phase code 0. Reset loads mid-scale.

Other behaviour can only be shown by the bench's scenarios:
- the exact floor values for negative sums;
- the modulo-64 mapping of negative phase products;
- the rail clamp, followed by immediate recovery on the next opposite sample;
- the clamped sample after an overlong window;
- the restart of the count after a strobe.

The bench also compares both outputs against an integer model on every clock.

// File: rtl/adpll_ctl_pkg.sv
package adpll_ctl_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;

  function automatic step_e decode_step(input logic up, input logic dn);
    if (up && !dn)      return STEP_INC;
    else if (dn && !up) return STEP_DEC;
    else                return STEP_HOLD;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/adpll_err_counter.sv
module adpll_err_counter
  import adpll_ctl_pkg::*;
#(
  parameter int ERR_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    up_i,
  input  logic                    dn_i,
  input  logic                    tick_i,
  output logic signed [ERR_W-1:0] sample_o,
  output logic                    vld_o
);

  localparam logic signed [ERR_W-1:0] EMAX = {1'b0, {(ERR_W-1){1'b1}}};
  localparam logic signed [ERR_W-1:0] EMIN = {1'b1, {(ERR_W-1){1'b0}}};
  localparam logic signed [ERR_W-1:0] ONE  = ERR_W'(1);

  logic signed [ERR_W-1:0] err_q;
  logic signed [ERR_W-1:0] err_n;
  step_e                   step;

  always_comb begin
    step  = decode_step(up_i, dn_i);
    err_n = err_q;
    case (step)
      STEP_INC: if (err_q != EMAX) err_n = err_q + ONE;
      STEP_DEC: if (err_q != EMIN) err_n = err_q - ONE;
      default:  err_n = err_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q    <= '0;
      sample_o <= '0;
      vld_o    <= 1'b0;
    end else begin
      vld_o <= tick_i;
      if (tick_i) begin
        sample_o <= err_n;
        err_q    <= '0;
      end else begin
        err_q    <= err_n;
      end
    end
  end

  // R1: coincident pulses leave the count unchanged
  a_r1_both_hold: assert property (@(posedge clk) disable iff (rst)
    (up_i && dn_i && !tick_i) |=> (err_q == $past(err_q)));

  // R10: a count at its upper limit does not wrap
  a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (err_q == EMAX && up_i && !dn_i && !tick_i) |=> (err_q == EMAX));

endmodule

// File: rtl/adpll_pi_tune.sv
module adpll_pi_tune
  import adpll_ctl_pkg::*;
#(
  parameter int ERR_W  = 24,
  parameter int INT_W  = 4,
  parameter int FRAC_W = 7,
  parameter int P1_SHR = 18,
  parameter int I_SHR  = 20
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic signed [ERR_W-1:0]   sample_i,
  input  logic                      vld_i,
  output logic [INT_W+FRAC_W-1:0]   tune_o
);

  localparam int TW   = INT_W + FRAC_W;
  localparam int FB   = max3(P1_SHR, I_SHR, FRAC_W);
  localparam int DROP = FB - FRAC_W;
  localparam int SW   = ERR_W + FB + TW + 2;

  localparam logic signed [SW-1:0] ONE_F  = SW'(1);
  localparam logic signed [SW-1:0] MID_F  = ONE_F <<< (TW - 1 + DROP);
  localparam logic signed [SW-1:0] IMAX_F = MID_F - ONE_F;
  localparam logic signed [SW-1:0] IMIN_F = -MID_F;
  localparam logic signed [SW-1:0] TMAX_F = (ONE_F <<< TW) - ONE_F;
  localparam logic [TW-1:0]        MID_W  = {1'b1, {(TW-1){1'b0}}};

  logic signed [SW-1:0] integ_q;
  logic signed [SW-1:0] samp_x;
  logic signed [SW-1:0] i_inc;
  logic signed [SW-1:0] p_term;
  logic signed [SW-1:0] i_sum;
  logic signed [SW-1:0] i_next;
  logic signed [SW-1:0] total;
  logic signed [SW-1:0] quot;
  logic [TW-1:0]        tune_n;

  always_comb begin
    samp_x = SW'(sample_i);
    i_inc  = samp_x <<< (FB - I_SHR);
    p_term = samp_x <<< (FB - P1_SHR);
    i_sum  = integ_q + i_inc;
    if (i_sum > IMAX_F)      i_next = IMAX_F;
    else if (i_sum < IMIN_F) i_next = IMIN_F;
    else                     i_next = i_sum;
    total = i_next + p_term + MID_F;
    quot  = total >>> DROP;
    if (quot < 0)            tune_n = '0;
    else if (quot > TMAX_F)  tune_n = '1;
    else                     tune_n = quot[TW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_q <= '0;
      tune_o  <= MID_W;
    end else if (vld_i) begin
      integ_q <= i_next;
      tune_o  <= tune_n;
    end
  end

  // R3: tuning word moves only after a strobe
  a_r3_tune_hold: assert property (@(posedge clk) disable iff (rst)
    (!vld_i) |=> $stable(tune_o));

  // R6: a non-negative sample never lowers the integrator (no wrap)
  a_r6_integ_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (vld_i && !sample_i[ERR_W-1]) |=> (integ_q >= $past(integ_q)));

endmodule

// File: rtl/adpll_phase_sel.sv
module adpll_phase_sel
  import adpll_ctl_pkg::*;
#(
  parameter int ERR_W  = 24,
  parameter int PSEL_W = 6,
  parameter int PS_SHL = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ERR_W-1:0] sample_i,
  input  logic                    vld_i,
  output logic [PSEL_W-1:0]       psel_o
);

  localparam int LSH = (PS_SHL > 0) ? PS_SHL : 0;
  localparam int EW  = ERR_W + PSEL_W + LSH;

  logic signed [EW-1:0] ext;
  logic [PSEL_W-1:0]    psel_n;

  always_comb ext = EW'(sample_i);

  generate
    if (PS_SHL >= 0) begin : g_gain_up
      logic signed [EW-1:0] prod;
      always_comb prod = ext <<< PS_SHL;
      always_comb psel_n = prod[PSEL_W-1:0];
    end else begin : g_gain_down
      logic signed [EW-1:0] prod;
      always_comb prod = ext >>> (-PS_SHL);
      always_comb psel_n = prod[PSEL_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        psel_o <= '0;
    else if (vld_i) psel_o <= psel_n;
  end

  // R7: no memory, a zero sample selects phase 0
  a_r7_zero_sample: assert property (@(posedge clk) disable iff (rst)
    (vld_i && sample_i == '0) |=> (psel_o == '0));

  // R3: phase index moves only after a strobe
  a_r3_psel_hold: assert property (@(posedge clk) disable iff (rst)
    (!vld_i) |=> $stable(psel_o));

endmodule

// File: rtl/adpll_loop_ctrl.sv
module adpll_loop_ctrl
  import adpll_ctl_pkg::*;
#(
  parameter int ERR_W  = 24,
  parameter int INT_W  = 4,
  parameter int FRAC_W = 7,
  parameter int PSEL_W = 6,
  parameter int P1_SHR = 18,
  parameter int I_SHR  = 20,
  parameter int PS_SHL = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    up_i,
  input  logic                    dn_i,
  input  logic                    ref_tick_i,
  output logic [INT_W+FRAC_W-1:0] tune_o,
  output logic [PSEL_W-1:0]       psel_o
);

  localparam int TW = INT_W + FRAC_W;
  localparam logic [TW-1:0] MID_W = {1'b1, {(TW-1){1'b0}}};

  logic signed [ERR_W-1:0] sample;
  logic                    sample_vld;

  adpll_err_counter #(.ERR_W(ERR_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .up_i     (up_i),
    .dn_i     (dn_i),
    .tick_i   (ref_tick_i),
    .sample_o (sample),
    .vld_o    (sample_vld)
  );

  adpll_pi_tune #(
    .ERR_W(ERR_W), .INT_W(INT_W), .FRAC_W(FRAC_W),
    .P1_SHR(P1_SHR), .I_SHR(I_SHR)
  ) u_tune (
    .clk      (clk),
    .rst      (rst),
    .sample_i (sample),
    .vld_i    (sample_vld),
    .tune_o   (tune_o)
  );

  adpll_phase_sel #(
    .ERR_W(ERR_W), .PSEL_W(PSEL_W), .PS_SHL(PS_SHL)
  ) u_psel (
    .clk      (clk),
    .rst      (rst),
    .sample_i (sample),
    .vld_i    (sample_vld),
    .psel_o   (psel_o)
  );

  // R9: reset loads mid-scale tuning and phase 0
  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (tune_o == MID_W && psel_o == '0));

endmodule

// File: tb/adpll_loop_ctrl_test.sv
module adpll_loop_ctrl_test;

  localparam int EW  = 10;
  localparam int IW  = 4;
  localparam int FW  = 7;
  localparam int PW  = 6;
  localparam int P1  = 9;
  localparam int IS  = 11;
  localparam int PSS = -1;
  localparam int FB  = 11;
  localparam int DRP = FB - FW;
  localparam longint MID = 1024;
  localparam longint TMX = 2047;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up = 1'b0, dn = 1'b0, tick = 1'b0;
  logic [IW+FW-1:0] tune;
  logic [PW-1:0]    psel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  adpll_loop_ctrl #(
    .ERR_W(EW), .INT_W(IW), .FRAC_W(FW), .PSEL_W(PW),
    .P1_SHR(P1), .I_SHR(IS), .PS_SHL(PSS)
  ) uut (
    .clk(clk), .rst(rst), .up_i(up), .dn_i(dn), .ref_tick_i(tick),
    .tune_o(tune), .psel_o(psel)
  );

  function automatic longint fdiv(longint a, longint b);
    longint q;
    q = a / b;
    if ((a % b != 0) && (a < 0)) q = q - 1;
    return q;
  endfunction

  function automatic longint clampl(longint v, longint lo, longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // behavioural reference
  longint m_err, m_smp, m_int, m_tune, m_psel;
  bit     m_vld;

  always @(posedge clk) begin
    if (rst) begin
      m_err = 0; m_smp = 0; m_int = 0; m_tune = MID; m_psel = 0; m_vld = 0;
    end else begin
      if (m_vld) begin
        longint ps;
        m_int  = clampl(m_int + m_smp * (64'sd1 <<< (FB - IS)),
                        -MID * (64'sd1 <<< DRP), MID * (64'sd1 <<< DRP) - 1);
        m_tune = clampl(fdiv(m_int + m_smp * (64'sd1 <<< (FB - P1)) + MID * (64'sd1 <<< DRP),
                             64'sd1 <<< DRP), 0, TMX);
        ps     = (PSS >= 0) ? m_smp * (64'sd1 <<< PSS) : fdiv(m_smp, 64'sd1 <<< (-PSS));
        m_psel = ((ps % 64) + 64) % 64;
      end
      m_err = clampl(m_err + longint'(up) - longint'(dn),
                     -(64'sd1 <<< (EW - 1)), (64'sd1 <<< (EW - 1)) - 1);
      if (tick) begin
        m_smp = m_err; m_err = 0; m_vld = 1;
      end else begin
        m_vld = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      checks++;
      if (longint'(tune) != m_tune) begin
        fails++;
        $display("FAIL R4 per-cycle tune: got %0d expected %0d", tune, m_tune);
      end
      checks++;
      if (longint'(psel) != m_psel) begin
        fails++;
        $display("FAIL R7 per-cycle psel: got %0d expected %0d", psel, m_psel);
      end
    end
  end

  task automatic chk(string req, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // drive a window of pulses, strobe, then wait until the outputs update
  task automatic window(int n_both, int n_up, int n_dn);
    for (int i = 0; i < n_both; i++) begin
      @(negedge clk); up = 1; dn = 1; tick = 0;
    end
    for (int i = 0; i < n_up; i++) begin
      @(negedge clk); up = 1; dn = 0; tick = 0;
    end
    for (int i = 0; i < n_dn; i++) begin
      @(negedge clk); up = 0; dn = 1; tick = 0;
    end
    @(negedge clk); up = 0; dn = 0; tick = 1;
    @(negedge clk); tick = 0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R9 reset tune", tune, 1024);
    chk("R9 reset psel", psel, 0);
    rst = 0;
    cmp_on = 1'b1;

    window(0, 20, 0);
    chk("R4 tune after +20", tune, 1030);
    chk("R7 psel after +20", psel, 10);

    window(0, 0, 0);
    chk("R4 integral held", tune, 1025);
    chk("R7 zero sample", psel, 0);

    window(0, 0, 30);
    chk("R5 floor negative", tune, 1015);
    chk("R8 wrap negative", psel, 49);

    window(7, 2, 0);
    chk("R1 both cancel tune", tune, 1024);
    chk("R1 both cancel psel", psel, 1);

    for (int k = 0; k < 40; k++) window(0, 500, 0);
    chk("R6 rail high", tune, 2047);
    chk("R8 psel 250 mod 64", psel, 58);

    window(0, 0, 100);
    chk("R6 off rail no wrap", tune, 2016);
    chk("R8 psel -50", psel, 14);

    window(0, 600, 0);
    chk("R10 count clamp psel", psel, 63);
    chk("R10 tune", tune, 2047);

    window(0, 4, 0);
    chk("R2 restart psel", psel, 2);

    for (int i = 0; i < 10; i++) begin
      @(negedge clk); up = 1; dn = 0; tick = 0;
    end
    chk("R3 hold psel", psel, 2);
    chk("R3 hold tune", tune, 2047);
    window(0, 0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule